// File: doc/BRIEF.md
# Prescaled Countdown Timer

This peripheral measures time in software-chosen units instead of raw clock cycles. Software writes a 32-bit division ratio and a 32-bit tick count over a simple word-addressed register bus, then sets a start bit. The block divides the system clock by the ratio. Each time the divider expires, the tick counter drops by one. When the tick counter reaches zero the block halts by itself. A stop bit halts it early and leaves the remaining count readable.

Both loadable registers come up as one and refuse writes while the timer is active. Status and the live tick count can be read at any time. Read data is registered and appears in the cycle after the select.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, status bit 0 reads 0, and both the divider register (word 0x0a) and the tick register (word 0x0b) read 1.
- R2: Word 0x0a reads back the programmed divider and word 0x0b reads the live tick counter. Control (0x08) and every unmapped word read as zero.
- R3: A read (cs_i=1, we_i=0) sampled at a clock edge puts its data on rdata_o after that edge. After any edge without a read, rdata_o is zero.
- R4: Writing control word 0x08 with bit 0 set starts an idle timer. Status word 0x09 bit 0 reads 1 from the next edge on.
- R5: With divider P and tick count T, the run lasts exactly P*T cycles. The tick counter drops by one every P cycles, and no cycle is lost when the divider reloads.
- R6: When the tick counter reaches zero, the run ends by itself: status bit 0 returns to 0 and word 0x0b reads 0.
- R7: Writing control bit 1 halts a run at once. The tick counter keeps its remaining value.
- R8: Writes to the divider and tick registers are ignored while running, and a later start reloads the old values.
- R9: When one control write sets both bit 0 and bit 1, the stop wins, whether the timer is idle or running.
- R10: A start written while the timer is already running is ignored, and the counters are not reloaded.
- R11: A start is ignored when the tick register holds zero. A divider of zero behaves as a divider of one.
- R12: Each start reloads the tick counter from the tick register, including after an early stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write enable (1 = write, 0 = read) |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The collisions that matter are between a bus action and a counter update landing on the same edge.

- A start or stop is written in the very cycle the divider expires. A control word is written with both bits set.
- A second start is issued a cycle after a tick decrement. The tick read that follows must show the decremented value, not a reload.
- Reads are placed on exact edges counted from the start write. This shows the pre-update value on the edge where the tick count changes and where the run ends, which exposes any lost or extra cycle at the reload.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned CTRL_WORD   = 8'h08;
  localparam int unsigned STATUS_WORD = 8'h09;
  localparam int unsigned PRESC_WORD  = 8'h0a;
  localparam int unsigned TICKS_WORD  = 8'h0b;
  localparam int unsigned START_BIT   = 0;
  localparam int unsigned STOP_BIT    = 1;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          running_i,
  input  logic [DW-1:0] tick_cnt_i,
  output logic [DW-1:0] presc_o,
  output logic [DW-1:0] load_o,
  output logic          start_o,
  output logic          stop_o,
  output logic          set_o,
  output logic [DW-1:0] set_val_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic          wr, rd;
  logic          presc_wr, load_wr;
  logic [DW-1:0] presc_q, load_q, rd_mux;

  assign wr       = cs_i && we_i;
  assign rd       = cs_i && !we_i;
  assign presc_wr = wr && !running_i && (addr_i == AW'(PRESC_WORD));
  assign load_wr  = wr && !running_i && (addr_i == AW'(TICKS_WORD));
  assign start_o  = wr && (addr_i == AW'(CTRL_WORD)) && wdata_i[START_BIT];
  assign stop_o   = wr && (addr_i == AW'(CTRL_WORD)) && wdata_i[STOP_BIT];
  assign set_o    = load_wr;
  assign set_val_o = wdata_i;
  assign presc_o  = presc_q;
  assign load_o   = load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= ONE;
      load_q  <= ONE;
    end else begin
      if (presc_wr) presc_q <= wdata_i;
      if (load_wr)  load_q  <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == AW'(STATUS_WORD))     rd_mux = {{(DW-1){1'b0}}, running_i};
    else if (addr_i == AW'(PRESC_WORD)) rd_mux = presc_q;
    else if (addr_i == AW'(TICKS_WORD)) rd_mux = tick_cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd ? rd_mux : '0;
  end

  assert_presc_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i |=> $stable(presc_q));
  assert_load_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i |=> $stable(load_q));
  assert_rdata_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && !we_i) |=> (rdata_o == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] presc_i,
  input  logic [DW-1:0] load_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          set_i,
  input  logic [DW-1:0] set_val_i,
  output logic          running_o,
  output logic [DW-1:0] tick_cnt_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic          running_q;
  logic [DW-1:0] presc_cnt_q, tick_cnt_q;
  logic          expire;

  // divider of 0 or 1 expires every cycle; reload happens on the expiring edge
  assign expire = (presc_cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q   <= 1'b0;
      presc_cnt_q <= '0;
      tick_cnt_q  <= ONE;
    end else if (stop_i) begin
      running_q <= 1'b0;
    end else if (start_i && !running_q) begin
      if (load_i != '0) begin
        running_q   <= 1'b1;
        presc_cnt_q <= presc_i;
        tick_cnt_q  <= load_i;
      end
    end else if (running_q) begin
      if (expire) begin
        presc_cnt_q <= presc_i;
        tick_cnt_q  <= tick_cnt_q - ONE;
        if (tick_cnt_q == ONE) running_q <= 1'b0;
      end else begin
        presc_cnt_q <= presc_cnt_q - ONE;
      end
    end else if (set_i) begin
      tick_cnt_q <= set_val_i;
    end
  end

  assign running_o  = running_q;
  assign tick_cnt_o = tick_cnt_q;

  assert_run_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> (tick_cnt_q != '0));
  assert_fall_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_q) |-> ((tick_cnt_q == '0) || $past(stop_i)));
  assert_single_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && $past(running_q) && !$past(start_i)) |->
      ((tick_cnt_q == $past(tick_cnt_q)) || (tick_cnt_q == $past(tick_cnt_q) - ONE)));
  assert_stop_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !running_q);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic          running, start, stop, set;
  logic [DW-1:0] tick_cnt, presc, load, set_val;

  tmr_regs #(.AW(AW), .DW(DW)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .running_i(running),
    .tick_cnt_i(tick_cnt), .presc_o(presc), .load_o(load),
    .start_o(start), .stop_o(stop), .set_o(set), .set_val_o(set_val),
    .rdata_o(rdata_o)
  );

  tmr_count #(.DW(DW)) count_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .presc_i(presc), .load_i(load),
    .start_i(start), .stop_i(stop), .set_i(set), .set_val_i(set_val),
    .running_o(running), .tick_cnt_o(tick_cnt)
  );

  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && start && !stop) |=> (tick_cnt != load) || ($past(tick_cnt) == load)
      || ($past(tick_cnt) - DW'(1) == load));
endmodule

// File: tb/prescaled_timer_tb_top.sv
module prescaled_timer_tb_top;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_wr = 0;
  bit done = 0;

  prescaled_timer #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    last_wr = cyc;
    cs_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    cs_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    cs_i = 1'b0;
    d = rdata_o;
  endtask

  // read whose sampling edge is edge number e
  task automatic rd_at(input int e, input logic [AW-1:0] a, output logic [DW-1:0] d);
    while (cyc < e - 1) @(negedge clk_i);
    rd(a, d);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(8'h09, v); check(v, 0, "R1 status");
    rd(8'h0a, v); check(v, 1, "R1 prescaler");
    rd(8'h0b, v); check(v, 1, "R1 ticks");
    rd(8'h08, v); check(v, 0, "R2 control reads zero");
    rd(8'h03, v); check(v, 0, "R2 unmapped");
    rd(8'h0a, v);
    @(negedge clk_i); check(rdata_o, 0, "R3 idle rdata");
  endtask

  task automatic t_basic();
    logic [DW-1:0] v;
    int k;
    wr(8'h0a, 3); wr(8'h0b, 4);
    rd(8'h0a, v); check(v, 3, "R2 prescaler readback");
    rd(8'h0b, v); check(v, 4, "R2 ticks readback");
    wr(8'h08, 1); k = last_wr;
    rd_at(k + 1, 8'h09, v);  check(v, 1, "R4 running");
    rd_at(k + 3, 8'h0b, v);  check(v, 4, "R5 before first tick");
    rd_at(k + 4, 8'h0b, v);  check(v, 3, "R5 first tick");
    rd_at(k + 7, 8'h0b, v);  check(v, 2, "R5 second tick no lost cycle");
    rd_at(k + 12, 8'h09, v); check(v, 1, "R5 still running at P*T");
    rd_at(k + 13, 8'h09, v); check(v, 0, "R6 self stop");
    rd_at(k + 14, 8'h0b, v); check(v, 0, "R6 counter zero");
  endtask

  task automatic t_stop_lock();
    logic [DW-1:0] v;
    int s;
    wr(8'h0a, 2); wr(8'h0b, 10);
    wr(8'h08, 1); s = last_wr;
    while (cyc < s + 4) @(negedge clk_i);
    wr(8'h08, 2);
    rd(8'h09, v); check(v, 0, "R7 stopped");
    rd(8'h0b, v); check(v, 8, "R7 residual held");
    wr(8'h08, 1); s = last_wr;
    rd_at(s + 1, 8'h0b, v); check(v, 10, "R12 reload after stop");
    while (cyc < s + 2) @(negedge clk_i);
    wr(8'h08, 1);
    rd_at(s + 4, 8'h0b, v); check(v, 9, "R10 start while running ignored");
    wr(8'h0a, 7); wr(8'h0b, 99);
    wr(8'h08, 2);
    rd(8'h0a, v); check(v, 2, "R8 prescaler locked");
    wr(8'h08, 1); s = last_wr;
    rd_at(s + 1, 8'h0b, v); check(v, 10, "R8 tick register locked");
    wr(8'h08, 2);
  endtask

  task automatic t_both();
    logic [DW-1:0] v;
    wr(8'h08, 3);
    rd(8'h09, v); check(v, 0, "R9 both bits while idle");
    wr(8'h08, 1);
    wr(8'h08, 3);
    rd(8'h09, v); check(v, 0, "R9 both bits while running");
  endtask

  task automatic t_zero();
    logic [DW-1:0] v;
    int k;
    wr(8'h0b, 0);
    wr(8'h08, 1);
    rd(8'h09, v); check(v, 0, "R11 zero tick start ignored");
    wr(8'h0a, 0); wr(8'h0b, 2);
    wr(8'h08, 1); k = last_wr;
    rd_at(k + 2, 8'h09, v); check(v, 1, "R11 zero divider runs 2 cycles");
    rd_at(k + 3, 8'h09, v); check(v, 0, "R11 zero divider stop");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_stop_lock();
    t_both();
    t_zero();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule